// File: doc/BRIEF.md
# XOR-Chain Memory Test Engine

This block tests a region of a single-port, 32-bit-wide memory without a processor. After a start pulse it writes a repeating three-word background into every word of the region. It then makes two chained passes over the region. In each pass, every word is replaced by its old value XORed with the value just written to the word before it. The first word of a pass is XORed with a fixed seed instead. Because each updated word is read back from memory before it feeds the next word, any stuck bit, bad write or bad read anywhere in the region is carried forward to the far end.

Only the three words at the far end are then read. They are compared against the rotation of the background that the region length modulo 3 predicts, and any differing bits are collected in a sticky 32-bit mask. A direction input chooses whether the chain runs from the low address upward or from the high address downward. The region bounds and the direction are captured at start, so the inputs may change while a test runs.

Top module: `xorChainTester`

## Requirements
- R1: If the region holds fewer than six words, or the last address is below the first, a start pulse issues no memory access. One cycle after the start, done=1, lenErr=1 and busy=0 are observed.
- R2: The fill writes the region from its near end, one word per cycle. The word at step k from the near end receives P[k mod 3], where P0=32'h6DB6DB6D, P1=32'hB6DB6DB6 and P2=32'hDB6DB6DB.
- R3: Exactly two XOR passes follow the fill, so a run makes 3N writes for N words. The first pass is seeded with P1 and the second with P0. In a fault-free memory, the word at step k ends holding P[(k+1) mod 3].
- R4: Each XOR step reads the word, writes the new value to the same address on the next cycle, and then reads it back. Read data is taken one cycle after the read request. A run makes 4N+3 reads.
- R5: After the passes, the three far-end words are read and each is XORed with its expected value, P[(k+1) mod 3] for its step k. The differing bits are ORed into badMask, so a fault-free region leaves badMask=0.
- R6: With descend=1 the near end is the last address and the steps go downward, so the three lowest words are the ones compared. With descend=0 the near end is the first address and the steps go upward.
- R7: Every memory access stays inside the inclusive region [firstAddr, lastAddr] captured at start. Words outside the region are never written.
- R8: busy is high from the cycle after an accepted start until done rises. done stays high until the next start. A start while busy is ignored, and so are changes to the region inputs while busy.
- R9: An accepted start clears badMask and lenErr. While a run is busy, bits of badMask are only ever set, never cleared.
- R10: A bit stuck at 0 in a word before the compared words, set to 1 by the fill, gives a nonzero badMask with that bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start pulse; accepted when not busy |
| descend | input | 1 | 1 runs the chain from lastAddr downward |
| firstAddr | input | ADDR_W | Lowest word address of the region |
| lastAddr | input | ADDR_W | Highest word address of the region (inclusive) |
| memReq | output | 1 | Memory access this cycle |
| memWe | output | 1 | 1 write, 0 read |
| memAddr | output | ADDR_W | Word address of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid the cycle after a read request |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished; held until the next start |
| lenErr | output | 1 | Last start was refused because the region is too short |
| badMask | output | 32 | Sticky mask of failing bit positions |

## Verification
The bound checker watches properties that must hold on every cycle. An error flag implies done with no memory traffic. Every access stays in the captured region. A write that directly follows a read targets the same address. done and busy never overlap, and done persists without a start. badMask only gains bits while busy and is zero right after an accepted start.

Some behaviour can only be shown by the bench's scenarios against a memory model. These are the exact fill sequence, the final contents of every word and the total counts of reads and writes that prove two passes. They also include the mask for each length-mod-3 case in both directions, and the detection of a stuck bit that is injected away from the compared words.

// File: rtl/xorTestPkg.sv
package xorTestPkg;

  localparam int WORD_W    = 32;
  localparam int MIN_WORDS = 6;

  localparam logic [WORD_W-1:0] PAT0 = 32'h6DB6DB6D;
  localparam logic [WORD_W-1:0] PAT1 = 32'hB6DB6DB6;
  localparam logic [WORD_W-1:0] PAT2 = 32'hDB6DB6DB;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FILL, ST_XRD, ST_XWR, ST_XRB, ST_CRD, ST_CCMP, ST_DONE
  } testState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic latch;      // capture region, reset pointer, phase and mask
    logic ptrNear;    // pointer to near end
    logic ptrCmp;     // pointer to first of the three compared words
    logic ptrStep;    // pointer one word toward the far end
    logic phaseStep;  // advance the mod-3 phase
    logic prevLoad;   // capture read-back of the previous updated word
    logic maskAcc;    // OR compare result into the mask
    logic firstWord;  // XOR with the seed instead of the previous word
    logic secondPass; // selects the seed of the second pass
    logic wrXor;      // write data is the XOR result, not the fill pattern
  } dpStrobe_t;

  function automatic logic [WORD_W-1:0] patOf(input logic [1:0] ph);
    case (ph)
      2'd0:    patOf = PAT0;
      2'd1:    patOf = PAT1;
      default: patOf = PAT2;
    endcase
  endfunction

  function automatic logic [1:0] nextPhase(input logic [1:0] ph);
    nextPhase = (ph == 2'd2) ? 2'd0 : ph + 2'd1;
  endfunction

endpackage

// File: rtl/xorTestDpath.sv
module xorTestDpath
  import xorTestPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [ADDR_W-1:0] endAddr,
  input  logic              descend,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              atFar,
  output logic              lenOk,
  output logic [WORD_W-1:0] badMask,
  output logic [ADDR_W-1:0] regionLo,
  output logic [ADDR_W-1:0] regionHi
);

  localparam logic [ADDR_W:0]   MIN_SPAN = (ADDR_W+1)'(MIN_WORDS - 1);
  localparam logic [ADDR_W-1:0] TWO      = ADDR_W'(2);

  logic [ADDR_W-1:0] loReg, hiReg, ptr;
  logic              descReg;
  logic [1:0]        phase;
  logic [WORD_W-1:0] prev, mask;

  logic [ADDR_W-1:0] nearAddr, farAddr, stepped, cmpStart;
  logic [ADDR_W:0]   span;
  logic [WORD_W-1:0] seed, xorVal;

  assign span     = {1'b0, endAddr} - {1'b0, startAddr};
  assign lenOk    = (endAddr >= startAddr) && (span >= MIN_SPAN);

  assign nearAddr = descReg ? hiReg : loReg;
  assign farAddr  = descReg ? loReg : hiReg;
  assign stepped  = descReg ? ptr - ADDR_W'(1) : ptr + ADDR_W'(1);
  assign cmpStart = descReg ? loReg + TWO : hiReg - TWO;
  assign atFar    = (ptr == farAddr);

  assign seed     = strb.secondPass ? PAT0 : PAT1;
  assign xorVal   = memRdata ^ (strb.firstWord ? seed : prev);
  assign memWdata = strb.wrXor ? xorVal : patOf(phase);
  assign memAddr  = ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loReg   <= '0;
      hiReg   <= '0;
      descReg <= 1'b0;
      ptr     <= '0;
      phase   <= 2'd0;
      prev    <= '0;
      mask    <= '0;
    end else if (strb.latch) begin
      loReg   <= startAddr;
      hiReg   <= endAddr;
      descReg <= descend;
      ptr     <= descend ? endAddr : startAddr;
      phase   <= 2'd0;
      mask    <= '0;
    end else begin
      if (strb.ptrNear)      ptr <= nearAddr;
      else if (strb.ptrCmp)  ptr <= cmpStart;
      else if (strb.ptrStep) ptr <= stepped;
      if (strb.phaseStep)    phase <= nextPhase(phase);
      if (strb.prevLoad)     prev <= memRdata;
      if (strb.maskAcc)      mask <= mask | (memRdata ^ patOf(nextPhase(phase)));
    end
  end

  assign badMask  = mask;
  assign regionLo = loReg;
  assign regionHi = hiReg;

endmodule

// File: rtl/xorTestCtrl.sv
module xorTestCtrl
  import xorTestPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      lenOk,
  input  logic      atFar,
  output dpStrobe_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      busy,
  output logic      done,
  output logic      lenErr
);

  testState_t state, nextState;
  logic       firstReg, passReg, errReg;

  always_comb begin
    strb            = '0;
    strb.firstWord  = firstReg;
    strb.secondPass = passReg;
    memReq          = 1'b0;
    memWe           = 1'b0;
    nextState       = state;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          strb.latch = 1'b1;
          nextState  = lenOk ? ST_FILL : ST_DONE;
        end
      end
      ST_FILL: begin
        memReq         = 1'b1;
        memWe          = 1'b1;
        strb.phaseStep = 1'b1;
        if (atFar) begin
          strb.ptrNear = 1'b1;
          nextState    = ST_XRD;
        end else begin
          strb.ptrStep = 1'b1;
        end
      end
      ST_XRD: begin
        memReq        = 1'b1;
        strb.prevLoad = 1'b1;
        nextState     = ST_XWR;
      end
      ST_XWR: begin
        memReq     = 1'b1;
        memWe      = 1'b1;
        strb.wrXor = 1'b1;
        nextState  = ST_XRB;
      end
      ST_XRB: begin
        memReq = 1'b1;
        if (!atFar) begin
          strb.ptrStep = 1'b1;
          nextState    = ST_XRD;
        end else if (!passReg) begin
          strb.ptrNear = 1'b1;
          nextState    = ST_XRD;
        end else begin
          strb.ptrCmp = 1'b1;
          nextState   = ST_CRD;
        end
      end
      ST_CRD: begin
        memReq    = 1'b1;
        nextState = ST_CCMP;
      end
      ST_CCMP: begin
        strb.maskAcc   = 1'b1;
        strb.phaseStep = 1'b1;
        if (atFar) begin
          nextState = ST_DONE;
        end else begin
          strb.ptrStep = 1'b1;
          nextState    = ST_CRD;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      firstReg <= 1'b0;
      passReg  <= 1'b0;
      errReg   <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.latch) begin
        firstReg <= 1'b1;
        passReg  <= 1'b0;
        errReg   <= !lenOk;
      end else if (state == ST_XWR) begin
        firstReg <= 1'b0;
      end else if (state == ST_XRB && atFar && !passReg) begin
        firstReg <= 1'b1;
        passReg  <= 1'b1;
      end
    end
  end

  assign busy   = (state != ST_IDLE) && (state != ST_DONE);
  assign done   = (state == ST_DONE);
  assign lenErr = errReg;

endmodule

// File: rtl/xorChainTester.sv
module xorChainTester
  import xorTestPkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              descend,
  input  logic [ADDR_W-1:0] firstAddr,
  input  logic [ADDR_W-1:0] lastAddr,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  output logic              busy,
  output logic              done,
  output logic              lenErr,
  output logic [WORD_W-1:0] badMask
);

  dpStrobe_t         strb;
  logic              atFar, lenOk;
  logic [ADDR_W-1:0] regionLo, regionHi;

  xorTestCtrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .lenOk  (lenOk),
    .atFar  (atFar),
    .strb   (strb),
    .memReq (memReq),
    .memWe  (memWe),
    .busy   (busy),
    .done   (done),
    .lenErr (lenErr)
  );

  xorTestDpath #(.ADDR_W(ADDR_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .startAddr (firstAddr),
    .endAddr   (lastAddr),
    .descend   (descend),
    .memRdata  (memRdata),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .atFar     (atFar),
    .lenOk     (lenOk),
    .badMask   (badMask),
    .regionLo  (regionLo),
    .regionHi  (regionHi)
  );

endmodule

// File: rtl/xorChainTesterChk.sv
module xorChainTesterChk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              lenErr,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       badMask,
  input logic [ADDR_W-1:0] regionLo,
  input logic [ADDR_W-1:0] regionHi
);

  AST_ERR_MEANS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> (done && !busy)); // R1

  AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> !memReq); // R1

  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && $past(memReq && !memWe)) |-> (memAddr == $past(memAddr))); // R4

  AST_ADDR_IN_REGION: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ((memAddr >= regionLo) && (memAddr <= regionHi))); // R7

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy)); // R8

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done); // R8

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ((badMask & $past(badMask)) == $past(badMask))); // R9

  AST_MASK_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (badMask == 32'd0)); // R9

endmodule

bind xorChainTester xorChainTesterChk #(.ADDR_W(ADDR_W)) i_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .lenErr   (lenErr),
  .memReq   (memReq),
  .memWe    (memWe),
  .memAddr  (memAddr),
  .badMask  (badMask),
  .regionLo (regionLo),
  .regionHi (regionHi)
);

// File: tb/test_xorChainTester.sv
module test_xorChainTester;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          descend = 1'b0;
  logic [AW-1:0] firstAddr = '0;
  logic [AW-1:0] lastAddr = '0;
  logic          memReq, memWe;
  logic [AW-1:0] memAddr;
  logic [31:0]   memWdata;
  logic [31:0]   memRdata = '0;
  logic          busy, done, lenErr;
  logic [31:0]   badMask;

  always #5 clk = ~clk;

  xorChainTester #(.ADDR_W(AW)) i_xorChainTester (
    .clk(clk), .rstN(rstN), .start(start), .descend(descend),
    .firstAddr(firstAddr), .lastAddr(lastAddr),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata),
    .busy(busy), .done(done), .lenErr(lenErr), .badMask(badMask)
  );

  // Memory model: one-cycle read latency, optional stuck-at-0 bit
  localparam logic [31:0] SENT = 32'hA5A5A5A5;
  logic [31:0]   mem [0:255];
  logic [AW-1:0] logA [0:1023];
  logic [31:0]   logD [0:1023];
  int            reqCnt = 0, wrCnt = 0, rdCnt = 0;
  logic          clearReq = 1'b0, faultOn = 1'b0;
  logic [AW-1:0] faultAddr = '0;
  logic [31:0]   faultMask = 32'h1;

  always @(posedge clk) begin
    if (clearReq) begin
      for (int i = 0; i < 256; i++) mem[i] <= SENT;
    end else if (memReq) begin
      reqCnt <= reqCnt + 1;
      if (memWe) begin
        mem[memAddr] <= (faultOn && memAddr == faultAddr) ? (memWdata & ~faultMask) : memWdata;
        if (wrCnt < 1024) begin
          logA[wrCnt] <= memAddr;
          logD[wrCnt] <= memWdata;
        end
        wrCnt <= wrCnt + 1;
      end else begin
        memRdata <= mem[memAddr];
        rdCnt    <= rdCnt + 1;
      end
    end
  end

  int totalCnt = 0, failCnt = 0;

  function automatic logic [31:0] pat(input int k);
    case (k % 3)
      0:       pat = 32'h6DB6DB6D;
      1:       pat = 32'hB6DB6DB6;
      default: pat = 32'hDB6DB6DB;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic clearMem();
    @(negedge clk) clearReq = 1'b1;
    @(negedge clk) clearReq = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 1000 && !done; i++) @(negedge clk);
  endtask

  // One full run; checks fill order, pass count, contents, mask and region bounds
  task automatic runCase(input string tag, input int lo, input int hi, input bit desc,
                         input bit withFault, input int fAddr,
                         input logic [31:0] expMask, input bit poke);
    int n, wr0, rd0, a;
    n = hi - lo + 1;
    clearMem();
    faultOn   = withFault;
    faultAddr = AW'(fAddr);
    @(negedge clk);
    firstAddr = AW'(lo); lastAddr = AW'(hi); descend = desc;
    wr0 = wrCnt; rd0 = rdCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !done, "R8", {tag, " busy after start"}, {30'd0, busy, done}, 32'h2);
    if (poke) begin
      repeat (10) @(negedge clk);
      start = 1'b1; firstAddr = '0; lastAddr = 8'd200; descend = !desc;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8", {tag, " start while busy ignored"}, {31'd0, busy}, 32'h1);
    end
    waitDone();
    chk(done && !lenErr, "R8", {tag, " done without error"}, {30'd0, done, lenErr}, 32'h2);
    chk(badMask == expMask, withFault ? "R10" : "R5", {tag, " bad mask"}, badMask, expMask);
    chk(wrCnt - wr0 == 3 * n, "R3", {tag, " write count"}, 32'(wrCnt - wr0), 32'(3 * n));
    chk(rdCnt - rd0 == 4 * n + 3, "R4", {tag, " read count"}, 32'(rdCnt - rd0), 32'(4 * n + 3));
    for (int k = 0; k < n; k++) begin
      a = desc ? hi - k : lo + k;
      chk(logA[wr0 + k] == AW'(a) && logD[wr0 + k] == pat(k), desc ? "R6" : "R2",
          {tag, " fill word"}, logD[wr0 + k], pat(k));
      if (!withFault)
        chk(mem[a] == pat(k + 1), "R3", {tag, " final word"}, mem[a], pat(k + 1));
    end
    chk(mem[lo - 1] == SENT && mem[hi + 1] == SENT, "R7", {tag, " outside untouched"},
        mem[hi + 1], SENT);
    repeat (5) @(negedge clk);
    chk(done && badMask == expMask, "R8", {tag, " done held"}, badMask, expMask);
    faultOn = 1'b0;
  endtask

  task automatic shortCase(input string tag, input int lo, input int hi);
    int r0;
    @(negedge clk);
    firstAddr = AW'(lo); lastAddr = AW'(hi); descend = 1'b0;
    r0 = reqCnt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done && lenErr && !busy, "R1", {tag, " refused at once"},
        {29'd0, done, lenErr, busy}, 32'h6);
    repeat (3) @(negedge clk);
    chk(reqCnt == r0, "R1", {tag, " no memory access"}, 32'(reqCnt - r0), 32'd0);
    chk(badMask == 32'd0, "R9", {tag, " mask cleared"}, badMask, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !lenErr && badMask == 0 && !memReq, "R8", "reset state",
        {27'd0, busy, done, lenErr, memReq, |badMask}, 32'd0);
    runCase("asc n6",  10, 15, 1'b0, 1'b0, 0, 32'd0, 1'b0);
    runCase("asc n7",  40, 46, 1'b0, 1'b0, 0, 32'd0, 1'b0);
    runCase("asc n8",  60, 67, 1'b0, 1'b0, 0, 32'd0, 1'b0);
    runCase("desc n7", 80, 86, 1'b1, 1'b0, 0, 32'd0, 1'b0);
    runCase("desc n8", 90, 97, 1'b1, 1'b0, 0, 32'd0, 1'b0);
    // R10: stuck-at-0 bit 0 at step 2 (filled with P2, bit 0 set)
    runCase("asc fault",  100, 107, 1'b0, 1'b1, 102, 32'h1, 1'b0);
    runCase("desc fault", 130, 138, 1'b1, 1'b1, 136, 32'h1, 1'b0);
    // R9: clean run after a failing one starts from a cleared mask
    runCase("clean after fault", 100, 107, 1'b0, 1'b0, 0, 32'd0, 1'b0);
    shortCase("five words", 20, 24);
    shortCase("reversed",   50, 40);
    runCase("poke while busy", 150, 158, 1'b0, 1'b0, 0, 32'd0, 1'b1);
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    totalCnt++;
    failCnt++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
    $finish;
  end

endmodule